// File: doc/BRIEF.md
# Dual Machine-Cycle Timer/Counter with Byte Auto-Reload

This block holds two independent 16-bit count channels for a small controller peripheral. Each channel advances in one of two ways. In timer use it steps once per machine cycle, and a shared prescaler makes one machine cycle from every twelve clocks. In counter use it steps on falling edges of its own external event pin. Each channel wraps in one of two ways. It can wrap as a full 16-bit counter. It can also run as an 8-bit counter in its low byte that reloads from its high byte. The reload form gives a steady stream of one-clock ticks whose spacing is set by the reload byte, so it serves as a serial baud-rate source.

Software loads the count bytes and the mode bits through a byte-wide write port. Each channel has its own run input, its own sticky overflow flag and a one-clock overflow pulse. The flag acts as an interrupt request and is cleared by a clear strobe, which may come from software or from an interrupt acknowledge.

Top module: `tmr_pair`

## Requirements
- R1: While reset is low, and after it is released, all flags and pulses are 0. Both count registers and all mode bits are 0, so a channel that is run with no writes counts as a 16-bit timer from 0x0000 and shows no overflow within 266 machine cycles.
- R2: In timer use, a running channel advances once per machine cycle of 12 clocks. Write addresses are: 0 for the channel 0 low byte, 1 for the channel 0 high byte, 2 for the channel 1 low byte, 3 for the channel 1 high byte and 4 for the mode byte. In 16-bit use, with a count of 0xFFF0, the channel overflows on the 16th machine-cycle step after run is raised.
- R3: In 16-bit use, an overflow from 0xFFFF wraps the count to 0x0000 and reloads nothing.
- R4: Mode byte bit 2*i+1 set to 1 puts channel i in reload use. In that use, a low byte at 0xFF takes the high byte on its next step and gives an overflow. The overflow pulse is exactly one clock wide.
- R5: In reload use, the overflow spacing is (256 - reload) machine cycles. A reload of 0xFD gives 36 clocks, 0xFA gives 72, 0xEE gives 216 and 0xDC gives 432.
- R6: Mode byte bit 2*i set to 1 selects counter use for channel i. The channel then steps once per 1-to-0 change of its event pin after a two-flop synchronizer, with the pin sampled once per machine cycle. Each pin level must be held for at least 14 clocks. In this use, machine cycles alone do not step the count.
- R7: With run at 0, a channel holds its count: neither machine cycles nor event edges step it. When run returns to 1, counting resumes from the held value.
- R8: An overflow sets the channel's flag in the same clock as its pulse. The flag then stays set until a clear strobe for that channel arrives. If an overflow and a clear fall in the same clock, the flag ends up set.
- R9: Each channel's count, flag and pulse are unaffected by the other channel's mode, run state and overflows.
- R10: A write to a count byte replaces that byte at once, and takes precedence over a step in the same clock. Counting continues from the written value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 8 | Register write data |
| run | input | 2 | Per-channel run enable |
| ev_pin | input | 2 | Per-channel external event pins, asynchronous |
| flag_clr | input | 2 | Per-channel overflow flag clear strobe |
| ovf_flag | output | 2 | Per-channel sticky overflow flag |
| ovf_pulse | output | 2 | Per-channel one-clock overflow pulse |

## Verification
The properties assume reset is applied at the start, and that a clear strobe is a deliberate one-clock request rather than a level. They also assume overflows can be no closer than one machine cycle apart, which the fixed prescale of twelve guarantees. The stimulus holds every event-pin level for thirty clocks, well above the synchronizer and sampling delay. It changes inputs only between rising edges. It aligns the simultaneous-clear case by counting clocks from an observed pulse, and not by relying on the prescaler phase.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int BYTE_W = 8;

  // Per-channel configuration taken from two bits of the mode byte.
  typedef struct packed {
    logic reload_mode;
    logic ext_sel;
  } chan_cfg_t;
endpackage

// File: rtl/tmr_prescale.sv
module tmr_prescale #(
  parameter int PRESCALE = 12,
  localparam int PW = (PRESCALE > 1) ? $clog2(PRESCALE) : 1
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam logic [PW-1:0] LAST = PW'(PRESCALE - 1);

  logic [PW-1:0] cnt_q;

  assign tick = (cnt_q == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n)    cnt_q <= '0;
    else if (tick) cnt_q <= '0;
    else           cnt_q <= cnt_q + PW'(1);
  end
endmodule

// File: rtl/tmr_edge_sync.sv
module tmr_edge_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic pin,
  output logic fall
);
  logic s1_q, s2_q, prev_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_q   <= 1'b0;
      s2_q   <= 1'b0;
      prev_q <= 1'b0;
    end else begin
      s1_q <= pin;
      s2_q <= s1_q;
      if (tick) prev_q <= s2_q;
    end
  end

  // A falling edge is recognised only at a machine-cycle sample point.
  assign fall = tick & prev_q & ~s2_q;
endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
  import tmr_pkg::*;
#(
  parameter int DW = BYTE_W,
  localparam int CW = 2 * DW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          ext_fall,
  input  logic          run,
  input  chan_cfg_t     cfg,
  input  logic          wr_lo,
  input  logic          wr_hi,
  input  logic [DW-1:0] wr_data,
  input  logic          flag_clr,
  output logic          ovf_flag,
  output logic          ovf_pulse
);
  localparam logic [DW-1:0] BYTE_MAX = '1;
  localparam logic [CW-1:0] FULL_MAX = '1;

  logic [DW-1:0] lo_q, hi_q;
  logic [CW-1:0] inc;
  logic          step, lo_wrap, ovf;

  always_comb begin
    step    = run & (cfg.ext_sel ? ext_fall : tick);
    inc     = {hi_q, lo_q} + CW'(1);
    lo_wrap = (lo_q == BYTE_MAX);
    ovf     = step & (cfg.reload_mode ? lo_wrap : ({hi_q, lo_q} == FULL_MAX));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lo_q      <= '0;
      hi_q      <= '0;
      ovf_pulse <= 1'b0;
      ovf_flag  <= 1'b0;
    end else begin
      if (wr_lo)
        lo_q <= wr_data;
      else if (step)
        lo_q <= (cfg.reload_mode && lo_wrap) ? hi_q : inc[DW-1:0];

      if (wr_hi)
        hi_q <= wr_data;
      else if (step && !cfg.reload_mode)
        hi_q <= inc[CW-1:DW];

      ovf_pulse <= ovf;
      ovf_flag  <= ovf | (ovf_flag & ~flag_clr);
    end
  end
endmodule

// File: rtl/tmr_pair.sv
module tmr_pair
  import tmr_pkg::*;
#(
  parameter int N_CH     = 2,
  parameter int PRESCALE = 12,
  parameter int DW       = BYTE_W,
  localparam int AW      = $clog2(2 * N_CH + 1),
  localparam int MW      = 2 * N_CH
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [AW-1:0]   wr_addr,
  input  logic [DW-1:0]   wr_data,
  input  logic [N_CH-1:0] run,
  input  logic [N_CH-1:0] ev_pin,
  input  logic [N_CH-1:0] flag_clr,
  output logic [N_CH-1:0] ovf_flag,
  output logic [N_CH-1:0] ovf_pulse
);
  localparam logic [AW-1:0] MODE_ADDR = AW'(2 * N_CH);

  logic          tick;
  logic [MW-1:0] mode_q;

  always_ff @(posedge clk) begin
    if (!rst_n)
      mode_q <= '0;
    else if (wr_en && wr_addr == MODE_ADDR)
      mode_q <= wr_data[MW-1:0];
  end

  tmr_prescale #(.PRESCALE(PRESCALE)) u_pre (
    .clk   (clk),
    .rst_n (rst_n),
    .tick  (tick)
  );

  for (genvar g = 0; g < N_CH; g++) begin : g_ch
    logic      fall;
    logic      wr_lo, wr_hi;
    chan_cfg_t cfg;

    assign wr_lo = wr_en && (wr_addr == AW'(2 * g));
    assign wr_hi = wr_en && (wr_addr == AW'(2 * g + 1));
    assign cfg   = chan_cfg_t'(mode_q[2*g +: 2]);

    tmr_edge_sync u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .tick  (tick),
      .pin   (ev_pin[g]),
      .fall  (fall)
    );

    tmr_channel #(.DW(DW)) u_chan (
      .clk       (clk),
      .rst_n     (rst_n),
      .tick      (tick),
      .ext_fall  (fall),
      .run       (run[g]),
      .cfg       (cfg),
      .wr_lo     (wr_lo),
      .wr_hi     (wr_hi),
      .wr_data   (wr_data),
      .flag_clr  (flag_clr[g]),
      .ovf_flag  (ovf_flag[g]),
      .ovf_pulse (ovf_pulse[g])
    );
  end
endmodule

// File: rtl/tmr_pair_chk.sv
module tmr_pair_chk #(
  parameter int N_CH = 2
) (
  input logic            clk,
  input logic            rst_n,
  input logic [N_CH-1:0] run,
  input logic [N_CH-1:0] flag_clr,
  input logic [N_CH-1:0] ovf_flag,
  input logic [N_CH-1:0] ovf_pulse
);
  for (genvar g = 0; g < N_CH; g++) begin : g_prop
    // R8
    flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ovf_flag[g] && !flag_clr[g]) |=> ovf_flag[g]);

    // R8
    pulse_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ovf_pulse[g] |-> ovf_flag[g]);

    // R8
    flag_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ovf_flag[g]) |-> ovf_pulse[g]);

    // R4
    pulse_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ovf_pulse[g] |=> !ovf_pulse[g]);

    // R7
    run_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ovf_pulse[g] |-> $past(run[g]));
  end
endmodule

bind tmr_pair tmr_pair_chk #(.N_CH(N_CH)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .run       (run),
  .flag_clr  (flag_clr),
  .ovf_flag  (ovf_flag),
  .ovf_pulse (ovf_pulse)
);

// File: tb/sim_tmr_pair.sv
`timescale 1ns/1ps
module sim_tmr_pair;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [2:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [1:0] run = '0;
  logic [1:0] ev_pin = 2'b11;
  logic [1:0] flag_clr = '0;
  logic [1:0] ovf_flag, ovf_pulse;

  int n_chk = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  tmr_pair u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .run(run), .ev_pin(ev_pin), .flag_clr(flag_clr),
    .ovf_flag(ovf_flag), .ovf_pulse(ovf_pulse)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic clr(input int ch);
    flag_clr[ch] = 1'b1;
    @(negedge clk);
    flag_clr[ch] = 1'b0;
  endtask

  // Counts edges from now until a pulse is seen, capped at maxc.
  task automatic wait_pulse(input int ch, input int maxc, output int n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!ovf_pulse[ch] && n < maxc);
  endtask

  task automatic count_pulses(input int ch, input int cyc, output int p);
    p = 0;
    for (int i = 0; i < cyc; i++) begin
      @(negedge clk);
      if (ovf_pulse[ch]) p++;
    end
  endtask

  task automatic t_reset();
    int p;
    chk(ovf_flag == 2'b00 && ovf_pulse == 2'b00, "R1 outputs in reset", ovf_flag, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(ovf_flag == 2'b00 && ovf_pulse == 2'b00, "R1 outputs after reset", ovf_flag, 0);
    run[0] = 1'b1;
    count_pulses(0, 3200, p);
    run[0] = 1'b0;
    chk(p == 0 && ovf_flag[0] == 1'b0, "R1 default 16-bit from zero", p, 0);
  endtask

  task automatic t_timer16();
    int n, p;
    wr(3'd4, 8'h00);
    wr(3'd1, 8'hFF);
    wr(3'd0, 8'hF0);
    run[0] = 1'b1;
    wait_pulse(0, 300, n);
    chk(n >= 181 && n <= 192, "R2 16 machine cycles to overflow", n, 186);
    chk(ovf_flag[0] == 1'b1, "R8 flag set with pulse", ovf_flag[0], 1);
    count_pulses(0, 3100, p);
    chk(p == 0, "R3 16-bit wrap has no reload", p, 0);
    chk(ovf_flag[0] == 1'b1, "R8 flag stays set", ovf_flag[0], 1);
    clr(0);
    chk(ovf_flag[0] == 1'b0, "R8 clear strobe", ovf_flag[0], 0);
  endtask

  task automatic t_baud();
    logic [7:0] vals [4] = '{8'hFD, 8'hFA, 8'hEE, 8'hDC};
    int n;
    run[0] = 1'b1;
    wr(3'd0, 8'h00);
    wr(3'd1, 8'h00);
    wr(3'd4, 8'h08);
    for (int k = 0; k < 4; k++) begin
      run[1] = 1'b0;
      wr(3'd3, vals[k]);
      wr(3'd2, vals[k]);
      run[1] = 1'b1;
      wait_pulse(1, 600, n);
      chk(ovf_pulse[1] == 1'b1, "R4 reload overflow seen", n, 0);
      @(negedge clk);
      chk(ovf_pulse[1] == 1'b0, "R4 pulse one clock wide", ovf_pulse[1], 0);
      wait_pulse(1, 600, n);
      chk(n + 1 == (256 - int'(vals[k])) * 12, "R5 reload spacing", n + 1,
          (256 - int'(vals[k])) * 12);
    end
    chk(ovf_flag[0] == 1'b0 && ovf_pulse[0] == 1'b0, "R9 channel 0 untouched", ovf_flag[0], 0);
    run[0] = 1'b0;
  endtask

  task automatic t_stop();
    int n, p;
    wr(3'd3, 8'hFD);
    wr(3'd2, 8'hFD);
    wait_pulse(1, 100, n);
    run[1] = 1'b0;
    count_pulses(1, 200, p);
    chk(p == 0, "R7 stopped timer holds", p, 0);
    run[1] = 1'b1;
    wait_pulse(1, 100, n);
    chk(n >= 25 && n <= 36, "R7 resume from held count", n, 30);
    // Next overflow is exactly 36 edges away: clear in that same clock.
    repeat (35) @(negedge clk);
    flag_clr[1] = 1'b1;
    @(negedge clk);
    flag_clr[1] = 1'b0;
    chk(ovf_pulse[1] == 1'b1 && ovf_flag[1] == 1'b1, "R8 set wins over clear",
        ovf_flag[1], 1);
    clr(1);
    chk(ovf_flag[1] == 1'b0, "R8 clear strobe channel 1", ovf_flag[1], 0);
    wr(3'd2, 8'hF0);
    wait_pulse(1, 300, n);
    chk(n >= 181 && n <= 192, "R10 write replaces low byte", n, 186);
    run[1] = 1'b0;
    clr(1);
  endtask

  task automatic t_counter();
    int n;
    wr(3'd4, 8'h03);
    wr(3'd1, 8'hFD);
    wr(3'd0, 8'hFD);
    clr(0);
    run[0] = 1'b1;
    repeat (2) begin
      ev_pin[0] = 1'b0; repeat (30) @(negedge clk);
      ev_pin[0] = 1'b1; repeat (30) @(negedge clk);
    end
    chk(ovf_flag[0] == 1'b0, "R6 two edges, no overflow, no timer steps", ovf_flag[0], 0);
    ev_pin[0] = 1'b0;
    wait_pulse(0, 40, n);
    chk(ovf_pulse[0] == 1'b1, "R6 third falling edge overflows", n, 14);
    ev_pin[0] = 1'b1; repeat (30) @(negedge clk);
    run[0] = 1'b0;
    clr(0);
    repeat (5) begin
      ev_pin[0] = 1'b0; repeat (30) @(negedge clk);
      ev_pin[0] = 1'b1; repeat (30) @(negedge clk);
    end
    chk(ovf_flag[0] == 1'b0, "R7 edges ignored while stopped", ovf_flag[0], 0);
    chk(ovf_flag[1] == 1'b0, "R9 channel 1 untouched", ovf_flag[1], 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    t_timer16();
    t_baud();
    t_stop();
    t_counter();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=150000 expected=0");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule